// File: doc/BRIEF.md
# Decimated PLL Lock Detector

This block decides whether a phase-locked loop is locked by watching two divided clocks: the reference-divided stream and the feedback-divided stream. Both streams are sampled by a fast sampling clock. Each stream passes through its own edge decimator, which emits a single-cycle strobe on every 64th rising edge. The time between a reference strobe and its partner feedback strobe, counted in sampling-clock ticks, is taken as one phase-error sample.

Each sample is graded against two programmable tick thresholds. A sample below the lock threshold is good. A sample above the unlock threshold is bad. A sample between them is neutral. The hysteresis is deliberately lopsided. Four consecutive good samples are needed to raise the lock flag, while one bad sample lowers it at once. If a strobe waits longer than twice the unlock threshold for its partner, the wait ends and is graded as bad.

An enable input holds the flag low and restarts the whole measurement chain. The thresholds would normally be set to the tick count equal to 10 ns at the chosen sampling rate.

Top module: `lock_detect_top`

## Requirements
- R1: A comparison strobe is produced only on every 64th rising edge of each divided input, counted from reset or from the enable rising; with 4-cycle input periods, no lock decision can be reached before about 1020 cycles after enabling.
- R2: The phase error is the number of sampling-clock cycles between the reference strobe and the feedback strobe, whichever comes first. Strobes in the same cycle give an error of 0. A second strobe from the side that is already waiting is ignored.
- R3: `lock_o` rises one cycle after the result of the fourth consecutive good comparison. A comparison is good only when its error is strictly less than `thr_lock_i`, so an error equal to `thr_lock_i` is not good.
- R4: While locked, one result with error strictly greater than `thr_unlock_i` clears `lock_o` in the cycle after that result. An error equal to `thr_unlock_i` does not clear it.
- R5: While `ld_en_i` is 0, `lock_o` is 0 from the next cycle on. The good-run count, the pending measurement and both decimators restart.
- R6: If the partner strobe has not arrived after 2·`thr_unlock_i` cycles of waiting, the comparison ends and counts as a bad result.
- R7: Any result that is not good resets the good-run count to zero. The count saturates at four.
- R8: `lock_o` is 0 during reset and after it.
- R9: A neutral result (error from `thr_lock_i` to `thr_unlock_i` inclusive), and any cycle with no result, leave `lock_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; phase error is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_div_i | input | 1 | Reference-divided clock, already synchronous to `clk` |
| fb_div_i | input | 1 | Feedback-divided clock, already synchronous to `clk` |
| thr_lock_i | input | TW (8) | Good-error limit in ticks (error must be below it) |
| thr_unlock_i | input | TW (8) | Bad-error limit in ticks (error above it drops lock) |
| ld_en_i | input | 1 | Lock detection enable; 0 forces the flag low |
| lock_o | output | 1 | Registered lock flag |

## Verification
The embedded assertions watch the following on every clock:
- a strobe is never followed by another from the same decimator in the next cycle;
- a measured error never exceeds the timeout window;
- a timeout result always counts as larger than the unlock threshold;
- a bad result always clears the flag;
- the flag rises only right after a good result;
- the flag holds across neutral results and across cycles with no result.

Some behaviours can only be shown by the bench's scenarios against its behavioural model:
- the 64-edge decimation;
- the four-in-a-row counting and its restart after a neutral sample;
- the exact threshold boundaries;
- feedback leading the reference;
- edges that arrive together;
- a feedback stream that goes silent.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Phase meter: which decimated edge arrived first and is waiting for its partner
  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_WAIT_FB  = 2'd1,
    MS_WAIT_REF = 2'd2
  } meas_state_t;

endpackage

// File: rtl/ld_edge_decim.sv
module ld_edge_decim #(
  parameter int DECIM = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sig_i,
  output logic strobe_o
);

  localparam int CW = (DECIM > 2) ? $clog2(DECIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(DECIM - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise, hit;

  always_comb begin
    rise  = sig_i & ~prev_q;
    hit   = rise && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (rise) begin
      cnt_d = hit ? '0 : cnt_q + ONE;
    end
  end

  assign strobe_o = en_i & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sig_i;
      cnt_q  <= cnt_d;
    end
  end

  // R1: a decimated strobe marks one rising edge, so it never repeats back to back
  p_strobe_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  // R5: no strobe leaves the decimator while detection is disabled
  p_strobe_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !strobe_o);

endmodule

// File: rtl/ld_phase_meter.sv
module ld_phase_meter
  import lockdet_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          ref_stb_i,
  input  logic          fb_stb_i,
  input  logic [TW-1:0] thr_unlock_i,
  output logic          vld_o,
  output logic [TW:0]   err_o,
  output logic          tmo_o
);

  localparam logic [TW:0] ONE = (TW + 1)'(1);

  meas_state_t state_q, state_d;
  logic [TW:0] cnt_q, cnt_d;
  logic [TW:0] err_q, err_d;
  logic        vld_q, vld_d;
  logic        tmo_q, tmo_d;
  logic [TW:0] limit;
  logic        partner;

  assign limit   = {thr_unlock_i, 1'b0};
  assign partner = (state_q == MS_WAIT_FB) ? fb_stb_i : ref_stb_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    tmo_d   = tmo_q;
    vld_d   = 1'b0;
    if (!en_i) begin
      state_d = MS_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        MS_IDLE: begin
          if (ref_stb_i && fb_stb_i) begin
            vld_d = 1'b1;
            err_d = '0;
            tmo_d = 1'b0;
          end else if (ref_stb_i) begin
            state_d = MS_WAIT_FB;
            cnt_d   = ONE;
          end else if (fb_stb_i) begin
            state_d = MS_WAIT_REF;
            cnt_d   = ONE;
          end
        end
        MS_WAIT_FB, MS_WAIT_REF: begin
          if (partner) begin
            vld_d   = 1'b1;
            err_d   = cnt_q;
            tmo_d   = 1'b0;
            state_d = MS_IDLE;
          end else if (cnt_q >= limit) begin
            vld_d   = 1'b1;
            err_d   = cnt_q;
            tmo_d   = 1'b1;
            state_d = MS_IDLE;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: state_d = MS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      err_q   <= '0;
      vld_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      vld_q   <= vld_d;
      tmo_q   <= tmo_d;
    end
  end

  assign vld_o = vld_q;
  assign err_o = err_q;
  assign tmo_o = tmo_q;

  // R2: results are single-cycle pulses
  p_result_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R2: a paired result never lies outside the waiting window
  p_err_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !tmo_q) |-> (err_q <= limit));

  // R6: a timed-out wait always grades as larger than the unlock threshold
  p_timeout_is_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && tmo_q) |-> (err_q > {1'b0, thr_unlock_i}));

endmodule

// File: rtl/ld_lock_filter.sv
module ld_lock_filter #(
  parameter int TW       = 8,
  parameter int LOCK_RUN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          vld_i,
  input  logic [TW:0]   err_i,
  input  logic          tmo_i,
  input  logic [TW-1:0] thr_lock_i,
  input  logic [TW-1:0] thr_unlock_i,
  output logic          lock_o
);

  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_RUN);
  localparam logic [RW-1:0] ONE     = RW'(1);

  logic [RW-1:0] run_q, run_d;
  logic          lock_q, lock_d;
  logic          good, bad;

  assign good = vld_i && !tmo_i && (err_i < {1'b0, thr_lock_i});
  assign bad  = vld_i && (tmo_i || (err_i > {1'b0, thr_unlock_i}));

  always_comb begin
    run_d  = run_q;
    lock_d = lock_q;
    if (!en_i) begin
      run_d  = '0;
      lock_d = 1'b0;
    end else if (vld_i) begin
      if (good) begin
        run_d = (run_q == RUN_MAX) ? run_q : run_q + ONE;
      end else begin
        run_d = '0;
      end
      if (bad) begin
        lock_d = 1'b0;
      end else if (good && (run_d == RUN_MAX)) begin
        lock_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

  // R3: the flag can only rise directly after a good result
  p_rise_after_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(good));

  // R4: a bad result drops the flag on the next cycle
  p_drop_on_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && bad) |=> !lock_q);

  // R5: disabled detection keeps the flag low
  p_en_forces_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !lock_q);

  // R9: a cycle without a result leaves the flag alone
  p_hold_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !vld_i) |=> $stable(lock_q));

  // R9: a neutral result leaves the flag alone
  p_hold_neutral_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && vld_i && !good && !bad) |=> $stable(lock_q));

endmodule

// File: rtl/lock_detect_top.sv
module lock_detect_top #(
  parameter int DECIM    = 64,
  parameter int TW       = 8,
  parameter int LOCK_RUN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_div_i,
  input  logic          fb_div_i,
  input  logic [TW-1:0] thr_lock_i,
  input  logic [TW-1:0] thr_unlock_i,
  input  logic          ld_en_i,
  output logic          lock_o
);

  localparam int NSTREAM = 2;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NSTREAM-1:0] raw_w;
  logic [NSTREAM-1:0] stb_w;
  logic               vld_w;
  logic [TW:0]        err_w;
  logic               tmo_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // index 0 is the reference stream, index 1 the feedback stream
  assign raw_w = {fb_div_i, ref_div_i};

  for (genvar gi = 0; gi < NSTREAM; gi++) begin : g_decim
    ld_edge_decim #(.DECIM(DECIM)) u_decim (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .en_i     (ld_en_i),
      .sig_i    (raw_w[gi]),
      .strobe_o (stb_w[gi])
    );
  end

  ld_phase_meter #(.TW(TW)) u_meter (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .en_i         (ld_en_i),
    .ref_stb_i    (stb_w[0]),
    .fb_stb_i     (stb_w[1]),
    .thr_unlock_i (thr_unlock_i),
    .vld_o        (vld_w),
    .err_o        (err_w),
    .tmo_o        (tmo_w)
  );

  ld_lock_filter #(.TW(TW), .LOCK_RUN(LOCK_RUN)) u_filter (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .en_i         (ld_en_i),
    .vld_i        (vld_w),
    .err_i        (err_w),
    .tmo_i        (tmo_w),
    .thr_lock_i   (thr_lock_i),
    .thr_unlock_i (thr_unlock_i),
    .lock_o       (lock_o)
  );

  // R8: no lock indication while the internal reset is held
  p_low_in_reset_r8: assert property (@(posedge clk)
    !rst_int_n |-> !lock_o);

endmodule

// File: tb/lock_detect_top_tb_top.sv
module lock_detect_top_tb_top;

  localparam int TW = 8;
  localparam int THR1 = 3;
  localparam int THR2 = 6;

  logic          clk;
  logic          rst_n;
  logic          ref_in;
  logic          fb_in;
  logic [TW-1:0] thr_lock;
  logic [TW-1:0] thr_unlock;
  logic          ld_en;
  logic          lock_o;

  integer n_checks = 0;
  integer n_errors = 0;
  bit     done = 0;

  lock_detect_top #(.DECIM(64), .TW(TW), .LOCK_RUN(4)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_div_i    (ref_in),
    .fb_div_i     (fb_in),
    .thr_lock_i   (thr_lock),
    .thr_unlock_i (thr_unlock),
    .ld_en_i      (ld_en),
    .lock_o       (lock_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- stimulus generator ----------------
  bit        gen_run = 0;
  bit        lead    = 0;
  bit        fb_mute = 0;
  integer    dly     = 1;
  logic [31:0] ph    = '0;
  logic [31:0] hist  = '0;

  initial begin
    ref_in = 1'b0;
    fb_in  = 1'b0;
  end

  always @(negedge clk) begin
    logic raw;
    logic del;
    raw = gen_run ? ph[1] : 1'b0;
    if (gen_run) ph = ph + 1;
    hist = {hist[30:0], raw};
    del  = hist[dly];
    ref_in = lead ? del : raw;
    fb_in  = fb_mute ? 1'b0 : (lead ? raw : del);
  end

  // ---------------- behavioural reference model ----------------
  integer m_cyc, m_rcnt, m_fcnt, m_pend, m_t0, m_run, m_cmps;
  bit     m_rprev, m_fprev, m_lock, m_rv, m_rgood, m_rbad;
  int     rst_age;

  task automatic m_result(input integer err, input bit tmo);
    m_rv    = 1;
    m_rgood = !tmo && (err < thr_lock);
    m_rbad  = tmo || (err > thr_unlock);
    m_cmps  = m_cmps + 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_rcnt = 0; m_fcnt = 0; m_pend = 0; m_t0 = 0;
      m_run = 0; m_lock = 0; m_rv = 0; m_rprev = 0; m_fprev = 0;
      m_rgood = 0; m_rbad = 0;
      if (m_cmps === 'x) m_cmps = 0;
    end else begin
      bit rr, fr, sr, sf;
      m_cyc = m_cyc + 1;
      // flag stage uses the result of the previous cycle
      if (!ld_en) begin
        m_run = 0; m_lock = 0;
      end else if (m_rv) begin
        if (m_rgood) m_run = (m_run >= 4) ? 4 : m_run + 1;
        else         m_run = 0;
        if (m_rbad)                      m_lock = 0;
        else if (m_rgood && m_run == 4)  m_lock = 1;
      end
      m_rv = 0;
      rr = ref_in && !m_rprev;
      fr = fb_in  && !m_fprev;
      m_rprev = ref_in;
      m_fprev = fb_in;
      if (!ld_en) begin
        m_rcnt = 0; m_fcnt = 0; m_pend = 0;
      end else begin
        sr = 0; sf = 0;
        if (rr) begin m_rcnt = m_rcnt + 1; if (m_rcnt == 64) begin sr = 1; m_rcnt = 0; end end
        if (fr) begin m_fcnt = m_fcnt + 1; if (m_fcnt == 64) begin sf = 1; m_fcnt = 0; end end
        if (m_pend == 0) begin
          if (sr && sf)  m_result(0, 0);
          else if (sr) begin m_pend = 1; m_t0 = m_cyc; end
          else if (sf) begin m_pend = 2; m_t0 = m_cyc; end
        end else begin
          integer k;
          k = m_cyc - m_t0;
          if ((m_pend == 1) ? sf : sr) begin m_result(k, 0); m_pend = 0; end
          else if (k >= 2 * thr_unlock) begin m_result(k, 1); m_pend = 0; end
        end
      end
    end
  end

  initial m_cmps = 0;

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks = n_checks + 1;
      if (lock_o !== m_lock) begin
        n_errors = n_errors + 1;
        $display("FAIL model compare (R3 R4 R9) t=%0t: lock_o=%b expected=%b", $time, lock_o, m_lock);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_errors = n_errors + 1;
      $display("FAIL %s: lock_o=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_delay(input integer d, input bit ld_lead);
    @(posedge clk); #1;
    gen_run = 0;
    repeat (40) @(posedge clk);
    #1;
    dly = d; lead = ld_lead; ph = '0; gen_run = 1;
  endtask

  task automatic restart(input integer d, input bit ld_lead);
    @(posedge clk); #1;
    ld_en = 0; gen_run = 0; fb_mute = 0;
    repeat (40) @(posedge clk);
    #1;
    dly = d; lead = ld_lead; ph = '0; gen_run = 1; ld_en = 1;
  endtask

  task automatic wait_cmps(input integer n);
    integer tgt;
    tgt = m_cmps + n;
    wait (m_cmps >= tgt);
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_checks = n_checks + 1;
    n_errors = n_errors + 1;
    $display("FAIL watchdog: run did not complete, lock_o=%b expected=end of sequence", lock_o);
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    rst_n = 1'b0; ld_en = 1'b1;
    thr_lock = TW'(THR1); thr_unlock = TW'(THR2);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(lock_o, 1'b0, "R8 flag low in reset");
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(lock_o, 1'b0, "R8 flag low after reset");

    // disabled detection with a well aligned loop
    @(posedge clk); #1; ld_en = 0; dly = 1; ph = '0; gen_run = 1;
    repeat (1300) @(posedge clk);
    @(negedge clk);
    chk(lock_o, 1'b0, "R5 enable low keeps flag low");

    // decimation and four-in-a-row lock timing
    restart(1, 0);
    repeat (1000) @(posedge clk);
    @(negedge clk);
    chk(lock_o, 1'b0, "R1 no lock before 256 decimated edges");
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(lock_o, 1'b1, "R3 lock after fourth good comparison");

    // error equal to unlock threshold keeps lock
    set_delay(THR2, 0);
    wait_cmps(2);
    chk(lock_o, 1'b1, "R4 error equal to unlock threshold holds lock");
    chk(lock_o, 1'b1, "R9 neutral results leave flag set");

    // one bad result drops lock
    set_delay(THR2 + 1, 0);
    wait_cmps(1);
    chk(lock_o, 1'b0, "R4 single bad result drops lock");

    // feedback leading the reference
    restart(2, 1);
    wait_cmps(3);
    chk(lock_o, 1'b0, "R3 three good results are not enough");
    wait_cmps(1);
    chk(lock_o, 1'b1, "R2 feedback-leading error measured as magnitude");

    // enable drop while locked
    @(posedge clk); #1; ld_en = 0;
    @(posedge clk);
    @(negedge clk);
    chk(lock_o, 1'b0, "R5 enable drop clears flag next cycle");

    // neutral result breaks the good run
    restart(1, 0);
    wait_cmps(3);
    chk(lock_o, 1'b0, "R7 three good results, still unlocked");
    set_delay(4, 0);
    wait_cmps(1);
    chk(lock_o, 1'b0, "R7 neutral result keeps flag low");
    set_delay(1, 0);
    wait_cmps(3);
    chk(lock_o, 1'b0, "R7 run restarted after neutral result");
    wait_cmps(1);
    chk(lock_o, 1'b1, "R7 four new good results lock");

    // error equal to lock threshold is not good
    restart(THR1, 0);
    wait_cmps(6);
    chk(lock_o, 1'b0, "R3 error equal to lock threshold never locks");

    // simultaneous edges
    restart(0, 0);
    wait_cmps(4);
    chk(lock_o, 1'b1, "R2 simultaneous edges give zero error and lock");

    // silent feedback: timeout
    @(posedge clk); #1; fb_mute = 1;
    wait_cmps(1);
    chk(lock_o, 1'b0, "R6 missing feedback edge times out as bad");

    // reset while locked
    restart(1, 0);
    wait_cmps(4);
    chk(lock_o, 1'b1, "R3 relock before reset test");
    @(posedge clk); #1; rst_n = 1'b0;
    #2;
    chk(lock_o, 1'b0, "R8 asynchronous reset clears flag");
    @(posedge clk); #1; gen_run = 0; rst_n = 1'b1;
    repeat (5) @(posedge clk);

    finish_run();
  end

endmodule